// File: doc/BRIEF.md
# Rice Code Integer Reconstruction Chain

This block reconstructs integers from a Rice-coded bit stream. Each chunk reaching it has already been classified: every bit carries a delimiter flag (it is the final bit of an integer), a remainder flag (it is one of the k binary remainder bits), and a spanning flag (it belongs to an integer that began in an earlier chunk). A chain of builder stages passes each chunk from stage to stage, one stage per cycle. Each stage takes one integer and hides the bits it used from the stages after it. An integer that runs past the end of a chunk stays with the stage that started it, and that stage completes it on the next chunk.

Each stage turns its integer into a binary quotient (the count of 1 bits in the unary part) joined to the k remainder bits. Delay lines then line the stage results up so that every output slot in a given cycle belongs to the same input chunk. A reorder network puts the integer that spanned into the chunk in the first slot. The integers that started in the chunk follow it in stream order.

Top module: `rice_int_builder_chain`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, every slot_vld_o bit and ovf_o are 0.
- R2: Integers that start and end in the same chunk come out in slots 1 upward, with no gaps, in the order they occur in the stream. Their slot_spn_o bit is 0.
- R3: Chunk bit 0 is the earliest bit of the stream. An integer is a run of 1s, then a 0, then K remainder bits, with the first remainder bit as the MSB. Its delimiter is the last remainder bit. Its result is {quotient, remainder}: the quotient takes the upper QW bits, the remainder the lower K bits, and the quotient is the number of 1s before the 0.
- R4: An integer that ends in a later chunk than it started is reported once, with the chunk that holds its delimiter, in slot 0 with slot_spn_o[0] = 1. This holds even when its unary part covers whole chunks that complete no integer of their own.
- R5: Results for a chunk sampled on clock edge e appear after edge e+NB-1 (NB = ceil((N-1)/(K+1))+1). All slots in that cycle come from that one chunk.
- R6: A cycle with vld_i low gives a cycle with no valid slot, and it does not disturb an integer that is still waiting for its delimiter.
- R7: A quotient larger than 2^QW-1 is reported as 2^QW-1. ovf_o then goes to 1 and stays at 1 until reset. A quotient of exactly 2^QW-1 leaves ovf_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | The chunk on the inputs is valid |
| dat_i | input | N | Chunk data bits, bit 0 earliest |
| del_i | input | N | Delimiter flags, 1 on the last bit of an integer |
| rem_i | input | N | Remainder flags, 1 on remainder bits |
| spn_i | input | N | Spanning flags, 1 on bits of an integer begun in an earlier chunk |
| slot_vld_o | output | NB | Slot holds a result |
| slot_spn_o | output | NB | Slot result spanned chunks |
| slot_val_o | output | NB*(QW+K) | Slot results, slot s at bits [s*(QW+K) +: QW+K] |
| ovf_o | output | 1 | Sticky quotient saturation flag |

## Verification
The bench builds the block with N=16, K=2 and QW=4. That gives a chain of six stages and six-bit results. The 4-bit quotient makes saturation reachable with a unary run of only 16 ones. An 18-bit integer can cross three 16-bit chunks, so one chunk contains nothing but spanning bits. The bench also tests a quotient of exactly 15 as the boundary case, runs bubbles between chunks, and places integers so that a chunk can hold the maximum number of complete results.

// File: rtl/rice_chain_pkg.sv
package rice_chain_pkg;

  typedef enum logic {BLD_IDLE = 1'b0, BLD_CARRY = 1'b1} bld_mode_e;

  // One stage per possible start, plus one for the stage still busy with a carried integer.
  function automatic int chain_len(input int n, input int k);
    return (n - 1 + k) / (k + 1) + 1;
  endfunction

endpackage

// File: rtl/rice_builder.sv
module rice_builder
  import rice_chain_pkg::*;
#(
  parameter int N  = 16,
  parameter int K  = 2,
  parameter int QW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [N-1:0]    dat_i,
  input  logic [N-1:0]    del_i,
  input  logic [N-1:0]    rem_i,
  input  logic [N-1:0]    spn_i,
  input  logic [N-1:0]    avl_i,
  output logic [N-1:0]    take_o,
  output logic            res_vld_o,
  output logic            res_spn_o,
  output logic [QW+K-1:0] res_val_o,
  output logic            sat_o
);
  localparam int CW = $clog2(N + 1);
  localparam int SW = QW + CW + 1;
  localparam logic [SW-1:0] QMAX = {{(SW-QW){1'b0}}, {QW{1'b1}}};

  bld_mode_e     mode_q;
  logic [QW-1:0] q_q;
  logic [K-1:0]  r_q;

  logic          open, fin, ovr;
  logic [N-1:0]  take;
  logic [CW-1:0] cnt;
  logic [K:0]    rr;
  logic [SW-1:0] qsum;
  logic [QW-1:0] qnew;

  always_comb begin
    open = (mode_q == BLD_CARRY);
    fin  = 1'b0;
    take = '0;
    cnt  = '0;
    rr   = {1'b0, (mode_q == BLD_CARRY) ? r_q : {K{1'b0}}};
    for (int i = 0; i < N; i++) begin
      // idle stage opens on the lowest unclaimed bit that does not belong to a carried integer
      if (!open && !fin && avl_i[i] && !spn_i[i]) open = 1'b1;
      if (open && !fin) begin
        take[i] = 1'b1;
        if (dat_i[i] && !rem_i[i]) cnt = cnt + CW'(1);
        if (rem_i[i]) rr = {rr[K-1:0], dat_i[i]};
        if (del_i[i]) fin = 1'b1;
      end
    end
    qsum = SW'(cnt) + ((mode_q == BLD_CARRY) ? SW'(q_q) : '0);
    ovr  = (qsum > QMAX);
    qnew = ovr ? {QW{1'b1}} : qsum[QW-1:0];
  end

  assign take_o = vld_i ? take : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= BLD_IDLE;
      q_q       <= '0;
      r_q       <= '0;
      res_vld_o <= 1'b0;
      res_spn_o <= 1'b0;
      res_val_o <= '0;
      sat_o     <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      sat_o     <= 1'b0;
      if (vld_i && |take) begin
        sat_o <= ovr;
        if (fin) begin
          res_vld_o <= 1'b1;
          res_spn_o <= (mode_q == BLD_CARRY);
          res_val_o <= {qnew, rr[K-1:0]};
          mode_q    <= BLD_IDLE;
        end else begin
          mode_q <= BLD_CARRY;
          q_q    <= qnew;
          r_q    <= rr[K-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/rice_align_delay.sv
module rice_align_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_shift
      logic [W-1:0] sh_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
        end else begin
          sh_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign q_o = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rice_slot_order.sv
module rice_slot_order #(
  parameter int NB = 6,
  parameter int VW = 10
) (
  input  logic [NB-1:0]    vld_i,
  input  logic [NB-1:0]    spn_i,
  input  logic [NB*VW-1:0] val_i,
  output logic [NB-1:0]    vld_o,
  output logic [NB-1:0]    spn_o,
  output logic [NB*VW-1:0] val_o
);
  int idx;

  always_comb begin
    vld_o = '0;
    spn_o = '0;
    val_o = '0;
    idx   = 1;
    // at most one carried integer finishes per chunk; it leads
    for (int j = 0; j < NB; j++) begin
      if (vld_i[j] && spn_i[j]) begin
        vld_o[0]     = 1'b1;
        spn_o[0]     = 1'b1;
        val_o[0+:VW] = val_i[j*VW +: VW];
      end
    end
    for (int j = 0; j < NB; j++) begin
      if (vld_i[j] && !spn_i[j] && idx < NB) begin
        vld_o[idx]          = 1'b1;
        val_o[idx*VW +: VW] = val_i[j*VW +: VW];
        idx                 = idx + 1;
      end
    end
  end
endmodule

// File: rtl/rice_int_builder_chain.sv
module rice_int_builder_chain
  import rice_chain_pkg::*;
#(
  parameter int N  = 16,
  parameter int K  = 2,
  parameter int QW = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 vld_i,
  input  logic [N-1:0]                         dat_i,
  input  logic [N-1:0]                         del_i,
  input  logic [N-1:0]                         rem_i,
  input  logic [N-1:0]                         spn_i,
  output logic [chain_len(N,K)-1:0]            slot_vld_o,
  output logic [chain_len(N,K)-1:0]            slot_spn_o,
  output logic [chain_len(N,K)*(QW+K)-1:0]     slot_val_o,
  output logic                                 ovf_o
);
  localparam int NB = chain_len(N, K);
  localparam int VW = QW + K;
  localparam int AW = VW + 2;

  logic         vld_s [NB];
  logic [N-1:0] dat_s [NB];
  logic [N-1:0] del_s [NB];
  logic [N-1:0] rem_s [NB];
  logic [N-1:0] spn_s [NB];
  logic [N-1:0] avl_s [NB];
  logic [N-1:0] take_s[NB];

  logic [NB-1:0]    bvld, bspn, bsat;
  logic [VW-1:0]    bval [NB];
  logic [NB-1:0]    avld, aspn;
  logic [NB*VW-1:0] aval;

  assign vld_s[0] = vld_i;
  assign dat_s[0] = dat_i;
  assign del_s[0] = del_i;
  assign rem_s[0] = rem_i;
  assign spn_s[0] = spn_i;
  assign avl_s[0] = '1;

  generate
    for (genvar j = 0; j < NB; j++) begin : g_stage
      logic [AW-1:0] a_q;

      rice_builder #(.N(N), .K(K), .QW(QW)) i_builder (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vld_i     (vld_s[j]),
        .dat_i     (dat_s[j]),
        .del_i     (del_s[j]),
        .rem_i     (rem_s[j]),
        .spn_i     (spn_s[j]),
        .avl_i     (avl_s[j]),
        .take_o    (take_s[j]),
        .res_vld_o (bvld[j]),
        .res_spn_o (bspn[j]),
        .res_val_o (bval[j]),
        .sat_o     (bsat[j])
      );

      if (j < NB - 1) begin : g_fwd
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            vld_s[j+1] <= 1'b0;
            dat_s[j+1] <= '0;
            del_s[j+1] <= '0;
            rem_s[j+1] <= '0;
            spn_s[j+1] <= '0;
            avl_s[j+1] <= '0;
          end else begin
            vld_s[j+1] <= vld_s[j];
            dat_s[j+1] <= dat_s[j];
            del_s[j+1] <= del_s[j];
            rem_s[j+1] <= rem_s[j];
            spn_s[j+1] <= spn_s[j];
            avl_s[j+1] <= avl_s[j] & ~take_s[j];
          end
        end
      end

      // later stages see the chunk later; pad earlier ones to match
      rice_align_delay #(.W(AW), .DEPTH(NB - 1 - j)) i_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({bvld[j], bspn[j], bval[j]}),
        .q_o    (a_q)
      );
      assign avld[j]           = a_q[AW-1];
      assign aspn[j]           = a_q[AW-2];
      assign aval[j*VW +: VW]  = a_q[VW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_o <= 1'b0;
    else if (|bsat) ovf_o <= 1'b1;
  end

  rice_slot_order #(.NB(NB), .VW(VW)) i_order (
    .vld_i (avld),
    .spn_i (aspn),
    .val_i (aval),
    .vld_o (slot_vld_o),
    .spn_o (slot_spn_o),
    .val_o (slot_val_o)
  );

endmodule

// File: rtl/rice_chain_chk.sv
module rice_chain_chk #(
  parameter int NB = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NB-1:0] slot_vld_o,
  input logic [NB-1:0] slot_spn_o,
  input logic          ovf_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (slot_vld_o == '0 && !ovf_o);
    end
  end

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r4_lead_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o[0] |-> slot_spn_o[0]);

  a_r4_flag_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_spn_o) && ((slot_spn_o & ~slot_vld_o) == '0));

  generate
    for (genvar s = 1; s < NB; s++) begin : g_slot
      a_r2_tail_unflagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s] |-> !slot_spn_o[s]);
      if (s >= 2) begin : g_pack
        a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
          slot_vld_o[s] |-> slot_vld_o[s-1]);
      end
    end
  endgenerate
endmodule

bind rice_int_builder_chain rice_chain_chk #(.NB(rice_chain_pkg::chain_len(N, K))) i_rice_chain_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slot_vld_o (slot_vld_o),
  .slot_spn_o (slot_spn_o),
  .ovf_o      (ovf_o)
);

// File: tb/test_rice_int_builder_chain.sv
`timescale 1ns/1ps
module test_rice_int_builder_chain;
  localparam int N    = 16;
  localparam int K    = 2;
  localparam int QW   = 4;
  localparam int NB   = (N - 1 + K) / (K + 1) + 1;
  localparam int VW   = QW + K;
  localparam int QMAX = (1 << QW) - 1;

  localparam int NV = 20;
  localparam int VEC [NV] = '{0, 1, 5, 2, 3, 12, 7, 0, 40, 2, 9, 4, 13, 1, 6, 3, 25, 0, 11, 8};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic vld_i = 1'b0;
  logic [N-1:0] dat_i = '0, del_i = '0, rem_i = '0, spn_i = '0;
  logic [NB-1:0]    slot_vld_o, slot_spn_o;
  logic [NB*VW-1:0] slot_val_o;
  logic             ovf_o;

  always #2.5 clk_i = ~clk_i;

  rice_int_builder_chain #(.N(N), .K(K), .QW(QW)) i_rice_int_builder_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .dat_i(dat_i), .del_i(del_i),
    .rem_i(rem_i), .spn_i(spn_i), .slot_vld_o(slot_vld_o), .slot_spn_o(slot_spn_o),
    .slot_val_o(slot_val_o), .ovf_o(ovf_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit sb [0:1023];
  bit sd [0:1023];
  bit sr [0:1023];
  int sid[0:1023];
  int ist[0:127], ien[0:127], iex[0:127];
  int nbits, nint;
  int slot_of[0:1023];

  task automatic push_bit(input bit b, input bit r, input bit d, input int id);
    sb[nbits] = b; sr[nbits] = r; sd[nbits] = d; sid[nbits] = id;
    nbits++;
  endtask

  // R3 encoding: q ones, a 0, then K remainder bits MSB first; delimiter on last remainder bit
  task automatic add_val(input int v);
    int q, r, id;
    q = v >> K; r = v & ((1 << K) - 1); id = nint;
    ist[id] = nbits;
    for (int i = 0; i < q; i++) push_bit(1'b1, 1'b0, 1'b0, id);
    push_bit(1'b0, 1'b0, 1'b0, id);
    for (int b = K - 1; b >= 0; b--) push_bit(bit'((r >> b) & 1), 1'b1, (b == 0), id);
    ien[id] = nbits - 1;
    iex[id] = (((q > QMAX) ? QMAX : q) << K) | r;
    nint++;
  endtask

  task automatic clear_stream();
    nbits = 0; nint = 0;
  endtask

  task automatic drive(input int c);
    int b;
    vld_i = (c >= 0);
    for (int i = 0; i < N; i++) begin
      b = c * N + i;
      if (c >= 0 && b < nbits) begin
        dat_i[i] = sb[b]; del_i[i] = sd[b]; rem_i[i] = sr[b];
        spn_i[i] = (ist[sid[b]] / N) < c;
      end else begin
        dat_i[i] = 1'b0; del_i[i] = 1'b0; rem_i[i] = 1'b0; spn_i[i] = 1'b0;
      end
    end
  endtask

  task automatic check_chunk(input int c, input string tag);
    logic [NB-1:0] ev, es;
    int ex [NB];
    int k;
    bit bad;
    ev = '0; es = '0; k = 1; bad = 1'b0;
    for (int s = 0; s < NB; s++) ex[s] = 0;
    if (c >= 0) begin
      for (int i = 0; i < nint; i++) begin
        if (ien[i] / N == c) begin
          if (ist[i] / N < c) begin ev[0] = 1'b1; es[0] = 1'b1; ex[0] = iex[i]; end
          else begin ev[k] = 1'b1; ex[k] = iex[i]; k++; end
        end
      end
    end
    checks++;
    if (slot_vld_o !== ev || slot_spn_o !== es) bad = 1'b1;
    for (int s = 0; s < NB; s++)
      if (ev[s] && slot_val_o[s*VW +: VW] !== VW'(ex[s])) bad = 1'b1;
    if (bad) begin
      errors++;
      $display("FAIL %s chunk %0d: vld %b spn %b val %h expected vld %b spn %b slot0 %0d slot1 %0d",
               tag, c, slot_vld_o, slot_spn_o, slot_val_o, ev, es, ex[0], ex[1]);
    end
  endtask

  // chunks with `gap` idle cycles between them; results checked NB cycles after being driven
  task automatic run_stream(input int gap, input string tag);
    int nch, cyc, total;
    nch = (nbits + N - 1) / N;
    cyc = 0;
    for (int t = 0; t < 1024; t++) slot_of[t] = -1;
    for (int c = 0; c < nch; c++) begin slot_of[cyc] = c; cyc += 1 + gap; end
    total = cyc + NB;
    for (int t = 0; t < total; t++) begin
      @(negedge clk_i);
      if (t >= NB) check_chunk(slot_of[t - NB], tag);
      drive((t < cyc) ? slot_of[t] : -1);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    drive(-1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_bit(|slot_vld_o, 1'b0, "R1 slots in reset");
    check_bit(ovf_o, 1'b0, "R1 ovf in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_bit(|slot_vld_o, 1'b0, "R1 slots after reset");
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check_bit(|slot_vld_o, 1'b0, "R1 slots at start");
    check_bit(ovf_o, 1'b0, "R1 ovf at start");
    rst_ni = 1'b1;

    // table stream: R2 R3 R4 R5
    clear_stream();
    for (int i = 0; i < NV; i++) add_val(VEC[i]);
    run_stream(0, "R2 R3 R4 R5 table");
    check_bit(ovf_o, 1'b0, "R7 no saturation in table");

    // same table with bubbles: R6
    do_reset();
    clear_stream();
    for (int i = 0; i < NV; i++) add_val(VEC[i]);
    run_stream(2, "R6 bubbles");

    // dense chunk of zeros, maximum complete results per chunk: R2
    do_reset();
    clear_stream();
    for (int i = 0; i < 16; i++) add_val(i & 3);
    run_stream(0, "R2 dense");

    // integer crossing three chunks, middle chunk all spanning; q = QMAX exactly: R4 R7
    do_reset();
    clear_stream();
    for (int i = 0; i < 5; i++) add_val(0);
    add_val(QMAX * 4 + 3);
    add_val(2);
    run_stream(1, "R4 three-chunk span");
    check_bit(ovf_o, 1'b0, "R7 boundary quotient no overflow");

    // saturation: R7
    do_reset();
    clear_stream();
    add_val(3);
    add_val(100);
    add_val(1);
    run_stream(0, "R7 saturate");
    check_bit(ovf_o, 1'b1, "R7 ovf set");
    repeat (3) @(negedge clk_i);
    check_bit(ovf_o, 1'b1, "R7 ovf sticky");
    do_reset();
    check_bit(ovf_o, 1'b0, "R1 ovf cleared by reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule